// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block steers a multicycle processor datapath (one that fetches, decodes, computes and writes back over several clock cycles) by reading its control lines from a small microcode store. A micro-address register selects one of ten microinstruction words. Each word holds the datapath control fields plus a two-bit sequencing code. The sequencing code decides where the micro-address goes next: one step forward, back to the fetch entry, or to a target found by looking up the opcode in one of two dispatch tables.

The only inputs are the clock, a synchronous active-high reset and the six-bit opcode of the instruction held in the datapath's instruction register. The control word is registered. The micro-address register and the output word are both loaded at the same clock edge from a single read of the store, so the outputs always show the entry the micro-address points at.

Top module: `ucode_seq`

## Requirements
- R1: While reset is high at a clock edge, the micro-address becomes 0 and the outputs show the fetch word: mem_rd, ir_wr and pc_wr are 1, alu_b_sel is 01 and every other output is 0.
- R2: Entry 0 (fetch) always moves on to entry 1, whatever the opcode is.
- R3: Entry 1 (decode) drives alu_a_sel=0, alu_b_sel=11, alu_op=00 and no write enables. It dispatches through the first table: opcode 000000 goes to 6, 000010 goes to 9, 000100 goes to 8, and 100011 or 101011 go to 2.
- R4: Entry 2 (address compute) drives alu_a_sel=1, alu_b_sel=10 and alu_op=00. It dispatches through the second table: 100011 goes to 3 and 101011 goes to 5.
- R5: A load (100011) runs through entries 0,1,2,3,4 and is back at fetch after 5 cycles. Entry 3 drives mem_rd=1 with addr_sel=1. Entry 4 drives reg_wr=1, dst_sel=0 (rt) and wb_sel=1 (memory data).
- R6: A store (101011) runs through entries 0,1,2,5 in 4 cycles. Entry 5 drives mem_wr=1 with addr_sel=1.
- R7: A register-format instruction (000000) runs through entries 0,1,6,7 in 4 cycles. Entry 6 drives alu_a_sel=1, alu_b_sel=00 and alu_op=10. Entry 7 drives reg_wr=1, dst_sel=1 (rd) and wb_sel=0 (ALU result).
- R8: A branch-on-equal (000100) runs through entries 0,1,8 in 3 cycles. Entry 8 drives alu_a_sel=1, alu_b_sel=00, alu_op=01, pc_wr_cond=1 and pc_src=01.
- R9: A jump (000010) runs through entries 0,1,9 in 3 cycles. Entry 9 drives pc_wr=1 and pc_src=10.
- R10: An opcode that the active dispatch table does not list sends the micro-address to 0 (fetch). An unknown opcode therefore takes 2 cycles, and an opcode that changes to a non-memory value while entry 2 is active returns to fetch.
- R11: In entries that step forward or restart (0, 3, 4, 5, 6, 7, 8, 9), the opcode has no effect on the next entry.
- R12: The micro-address never leaves the range 0 to 9. mem_rd and mem_wr are never both 1, and pc_wr and pc_wr_cond are never both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | OP_W | Opcode field of the current instruction |
| pc_wr | output | 1 | Unconditional program counter write |
| pc_wr_cond | output | 1 | Program counter write when the ALU reports zero |
| addr_sel | output | 1 | Memory address source: 0 program counter, 1 ALU result register |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| ir_wr | output | 1 | Instruction register load |
| wb_sel | output | 1 | Register write data: 0 ALU result, 1 memory data |
| pc_src | output | 2 | Program counter source: 00 ALU, 01 ALU result register, 10 jump target |
| alu_op | output | 2 | 00 add, 01 subtract, 10 use function code |
| alu_b_sel | output | 2 | ALU B input: 00 register B, 01 constant 4, 10 extended immediate, 11 extended immediate shifted by 2 |
| alu_a_sel | output | 1 | ALU A input: 0 program counter, 1 register A |
| reg_wr | output | 1 | Register file write |
| dst_sel | output | 1 | Destination register: 0 rt field, 1 rd field |

## Verification
The assertions check four things on every cycle: the micro-address stays inside the ten entries, the memory and program-counter enables never overlap, a register write is always followed by a fetch, and a fetch is always followed by decode. Only the bench scenarios can show that each opcode reaches the right dispatch target, and that each instruction class takes the right number of cycles. They also show that unlisted or changed opcodes fall back to fetch, and that the opcode is ignored in the stepping entries. The bench does this by comparing every output bit with a reference sequence it computes cycle by cycle.

// File: rtl/ucode_seq_pkg.sv
package ucode_seq_pkg;

  typedef enum logic [1:0] {
    SQ_RESTART  = 2'b00,
    SQ_TABLE_A  = 2'b01,
    SQ_TABLE_B  = 2'b10,
    SQ_STEP     = 2'b11
  } seq_e;

  typedef struct packed {
    logic       pc_wr;
    logic       pc_wr_cond;
    logic       addr_sel;
    logic       mem_rd;
    logic       mem_wr;
    logic       ir_wr;
    logic       wb_sel;
    logic [1:0] pc_src;
    logic [1:0] alu_op;
    logic [1:0] alu_b_sel;
    logic       alu_a_sel;
    logic       reg_wr;
    logic       dst_sel;
  } ctl_t;

  typedef struct packed {
    ctl_t ctl;
    seq_e seq;
  } uword_t;

  localparam logic [5:0] OPC_REG   = 6'b000000;
  localparam logic [5:0] OPC_JMP   = 6'b000010;
  localparam logic [5:0] OPC_BEQ   = 6'b000100;
  localparam logic [5:0] OPC_LOAD  = 6'b100011;
  localparam logic [5:0] OPC_STORE = 6'b101011;

endpackage

// File: rtl/ucs_store.sv
module ucs_store
  import ucode_seq_pkg::*;
#(
  parameter int UA_W     = 4,
  parameter int UC_DEPTH = 10
) (
  input  logic [UA_W-1:0] addr,
  output uword_t          word
);
  always_comb begin
    word     = '0;
    word.seq = SQ_RESTART;
    if (int'(addr) < UC_DEPTH) begin
      case (int'(addr))
        0: begin
          word.ctl.mem_rd    = 1'b1;
          word.ctl.ir_wr     = 1'b1;
          word.ctl.alu_b_sel = 2'b01;
          word.ctl.pc_wr     = 1'b1;
          word.seq           = SQ_STEP;
        end
        1: begin
          word.ctl.alu_b_sel = 2'b11;
          word.seq           = SQ_TABLE_A;
        end
        2: begin
          word.ctl.alu_a_sel = 1'b1;
          word.ctl.alu_b_sel = 2'b10;
          word.seq           = SQ_TABLE_B;
        end
        3: begin
          word.ctl.mem_rd   = 1'b1;
          word.ctl.addr_sel = 1'b1;
          word.seq          = SQ_STEP;
        end
        4: begin
          word.ctl.reg_wr = 1'b1;
          word.ctl.wb_sel = 1'b1;
        end
        5: begin
          word.ctl.mem_wr   = 1'b1;
          word.ctl.addr_sel = 1'b1;
        end
        6: begin
          word.ctl.alu_a_sel = 1'b1;
          word.ctl.alu_op    = 2'b10;
          word.seq           = SQ_STEP;
        end
        7: begin
          word.ctl.reg_wr  = 1'b1;
          word.ctl.dst_sel = 1'b1;
        end
        8: begin
          word.ctl.alu_a_sel  = 1'b1;
          word.ctl.alu_op     = 2'b01;
          word.ctl.pc_wr_cond = 1'b1;
          word.ctl.pc_src     = 2'b01;
        end
        9: begin
          word.ctl.pc_wr  = 1'b1;
          word.ctl.pc_src = 2'b10;
        end
        default: word = '0;
      endcase
    end
  end
endmodule

// File: rtl/ucs_dispatch.sv
module ucs_dispatch
  import ucode_seq_pkg::*;
#(
  parameter int UA_W  = 4,
  parameter int OP_W  = 6,
  parameter int TABLE = 1
) (
  input  logic [OP_W-1:0] opcode,
  output logic [UA_W-1:0] target
);
  generate
    if (TABLE == 1) begin : g_first
      always_comb begin
        case (opcode)
          OP_W'(OPC_REG):   target = UA_W'(6);
          OP_W'(OPC_JMP):   target = UA_W'(9);
          OP_W'(OPC_BEQ):   target = UA_W'(8);
          OP_W'(OPC_LOAD),
          OP_W'(OPC_STORE): target = UA_W'(2);
          default:          target = '0;
        endcase
      end
    end else begin : g_second
      always_comb begin
        case (opcode)
          OP_W'(OPC_LOAD):  target = UA_W'(3);
          OP_W'(OPC_STORE): target = UA_W'(5);
          default:          target = '0;
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/ucs_nextaddr.sv
module ucs_nextaddr
  import ucode_seq_pkg::*;
#(
  parameter int UA_W = 4,
  parameter int OP_W = 6
) (
  input  logic [UA_W-1:0] upc,
  input  seq_e            seq,
  input  logic [OP_W-1:0] opcode,
  output logic [UA_W-1:0] nxt
);
  logic [UA_W-1:0] tgt_a;
  logic [UA_W-1:0] tgt_b;

  ucs_dispatch #(.UA_W(UA_W), .OP_W(OP_W), .TABLE(1)) u_tab_a (
    .opcode(opcode), .target(tgt_a));
  ucs_dispatch #(.UA_W(UA_W), .OP_W(OP_W), .TABLE(2)) u_tab_b (
    .opcode(opcode), .target(tgt_b));

  always_comb begin
    case (seq)
      SQ_TABLE_A: nxt = tgt_a;
      SQ_TABLE_B: nxt = tgt_b;
      SQ_STEP:    nxt = UA_W'(upc + 1'b1);
      default:    nxt = '0;
    endcase
  end
endmodule

// File: rtl/ucode_seq.sv
module ucode_seq
  import ucode_seq_pkg::*;
#(
  parameter int OP_W     = 6,
  parameter int UA_W     = 4,
  parameter int UC_DEPTH = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] opcode,
  output logic            pc_wr,
  output logic            pc_wr_cond,
  output logic            addr_sel,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic            ir_wr,
  output logic            wb_sel,
  output logic [1:0]      pc_src,
  output logic [1:0]      alu_op,
  output logic [1:0]      alu_b_sel,
  output logic            alu_a_sel,
  output logic            reg_wr,
  output logic            dst_sel
);
  logic [UA_W-1:0] upc_q;
  logic [UA_W-1:0] nxt;
  logic [UA_W-1:0] rd_addr;
  uword_t          rd_word;
  uword_t          word_q;

  ucs_nextaddr #(.UA_W(UA_W), .OP_W(OP_W)) u_next (
    .upc(upc_q), .seq(word_q.seq), .opcode(opcode), .nxt(nxt));

  assign rd_addr = rst ? '0 : nxt;

  ucs_store #(.UA_W(UA_W), .UC_DEPTH(UC_DEPTH)) u_store (
    .addr(rd_addr), .word(rd_word));

  always_ff @(posedge clk) begin
    upc_q  <= rd_addr;
    word_q <= rd_word;
  end

  assign pc_wr      = word_q.ctl.pc_wr;
  assign pc_wr_cond = word_q.ctl.pc_wr_cond;
  assign addr_sel   = word_q.ctl.addr_sel;
  assign mem_rd     = word_q.ctl.mem_rd;
  assign mem_wr     = word_q.ctl.mem_wr;
  assign ir_wr      = word_q.ctl.ir_wr;
  assign wb_sel     = word_q.ctl.wb_sel;
  assign pc_src     = word_q.ctl.pc_src;
  assign alu_op     = word_q.ctl.alu_op;
  assign alu_b_sel  = word_q.ctl.alu_b_sel;
  assign alu_a_sel  = word_q.ctl.alu_a_sel;
  assign reg_wr     = word_q.ctl.reg_wr;
  assign dst_sel    = word_q.ctl.dst_sel;

  AST_RESET_FETCH: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ir_wr && mem_rd && pc_wr)); // R1
  AST_FETCH_TO_DECODE: assert property (@(posedge clk) disable iff (rst)
    (ir_wr && !$past(rst)) |=> (alu_b_sel == 2'b11 && !ir_wr)); // R2
  AST_WRITE_TO_FETCH: assert property (@(posedge clk) disable iff (rst)
    reg_wr |=> (ir_wr && mem_rd)); // R5
  AST_UPC_RANGE: assert property (@(posedge clk) disable iff (rst)
    int'(upc_q) < UC_DEPTH); // R12
  AST_MEM_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr)); // R12
  AST_PC_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(pc_wr && pc_wr_cond)); // R12
endmodule

// File: tb/ucode_seq_tb_top.sv
module ucode_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] O_REG = 6'b000000, O_JMP = 6'b000010, O_BEQ = 6'b000100,
                         O_LD = 6'b100011, O_ST = 6'b101011;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [5:0] opcode = '0;
  logic pc_wr, pc_wr_cond, addr_sel, mem_rd, mem_wr, ir_wr, wb_sel;
  logic [1:0] pc_src, alu_op, alu_b_sel;
  logic alu_a_sel, reg_wr, dst_sel;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int m_upc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ucode_seq dut_i (
    .clk(clk), .rst(rst), .opcode(opcode),
    .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .addr_sel(addr_sel),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_wr(ir_wr), .wb_sel(wb_sel),
    .pc_src(pc_src), .alu_op(alu_op), .alu_b_sel(alu_b_sel),
    .alu_a_sel(alu_a_sel), .reg_wr(reg_wr), .dst_sel(dst_sel));

  // {pc_wr,pc_wr_cond,addr_sel,mem_rd,mem_wr,ir_wr,wb_sel,pc_src,alu_op,alu_b,alu_a,reg_wr,dst}
  function automatic logic [15:0] exp_word(int u);
    case (u)
      0: return {1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,2'b00,2'b00,2'b01,1'b0,1'b0,1'b0};
      1: return {7'b0,2'b00,2'b00,2'b11,3'b000};
      2: return {7'b0,2'b00,2'b00,2'b10,3'b100};
      3: return {1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,2'b00,2'b00,2'b00,3'b000};
      4: return {6'b0,1'b1,2'b00,2'b00,2'b00,1'b0,1'b1,1'b0};
      5: return {1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,2'b00,2'b00,2'b00,3'b000};
      6: return {7'b0,2'b00,2'b10,2'b00,3'b100};
      7: return {7'b0,2'b00,2'b00,2'b00,3'b011};
      8: return {1'b0,1'b1,5'b0,2'b01,2'b01,2'b00,3'b100};
      9: return {1'b1,6'b0,2'b10,2'b00,2'b00,3'b000};
      default: return 16'hFFFF;
    endcase
  endfunction

  function automatic int next_upc(int u, logic [5:0] op);
    case (u)
      0, 3, 6: return u + 1;
      1: case (op)
           O_REG: return 6;
           O_JMP: return 9;
           O_BEQ: return 8;
           O_LD, O_ST: return 2;
           default: return 0;
         endcase
      2: case (op)
           O_LD: return 3;
           O_ST: return 5;
           default: return 0;
         endcase
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(int u);
    case (u)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3, 4: return "R5";
      5: return "R6";
      6, 7: return "R7";
      8: return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [15:0] outs();
    return {pc_wr,pc_wr_cond,addr_sel,mem_rd,mem_wr,ir_wr,wb_sel,
            pc_src,alu_op,alu_b_sel,alu_a_sel,reg_wr,dst_sel};
  endfunction

  task automatic check_word(string tag);
    total++;
    if (outs() !== exp_word(m_upc)) begin
      bad++;
      $display("FAIL %s entry=%0d actual=%h expected=%h", tag, m_upc, outs(), exp_word(m_upc));
    end
  endtask

  // drive op at a negedge, then check the resulting entry at the next negedge
  task automatic step(logic [5:0] op, string tag);
    opcode = op;
    m_upc = next_upc(m_upc, op);
    @(negedge clk);
    check_word(tag == "" ? tag_of(m_upc) : tag);
  endtask

  task automatic run_instr(logic [5:0] op, int exp_len, string tag);
    int n = 0;
    do begin
      step(op, tag);
      n++;
    end while (!ir_wr && n < 20);
    total++;
    if (n != exp_len) begin
      bad++;
      $display("FAIL %s cycles actual=%0d expected=%0d", tag, n, exp_len);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    logic [5:0] cur;
    void'($urandom(32'd4242));
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    m_upc = 0;
    check_word("R1");
    rst = 1'b0;
    // directed sequences
    run_instr(O_LD, 5, "R5");
    run_instr(O_ST, 4, "R6");
    run_instr(O_REG, 4, "R7");
    run_instr(O_BEQ, 3, "R8");
    run_instr(O_JMP, 3, "R9");
    run_instr(6'b111111, 2, "R10");
    run_instr(6'b001000, 2, "R10");
    // opcode changes away from memory ops while in entry 2
    step(O_LD, "R2");
    step(O_LD, "R3");
    step(O_BEQ, "R10");
    total++;
    if (!ir_wr) begin
      bad++;
      $display("FAIL R10 ir_wr actual=%0b expected=1", ir_wr);
    end
    // opcode ignored in step/restart entries
    step(O_BEQ, "R11");
    step(O_REG, "R11");
    step(O_JMP, "R11");
    step(O_LD, "R11");
    total++;
    if (!ir_wr) begin
      bad++;
      $display("FAIL R11 ir_wr actual=%0b expected=1", ir_wr);
    end
    // reset in the middle of an instruction
    step(O_LD, "R2");
    step(O_LD, "R4");
    rst = 1'b1;
    @(negedge clk);
    m_upc = 0;
    check_word("R1");
    rst = 1'b0;
    // random phase
    cur = O_LD;
    for (int i = 0; i < 3000; i++) begin
      logic [5:0] op;
      if (m_upc == 0 && ($urandom % 4) == 0) begin
        case ($urandom % 7)
          0: cur = O_REG;
          1: cur = O_JMP;
          2: cur = O_BEQ;
          3: cur = O_LD;
          4: cur = O_ST;
          default: cur = 6'($urandom);
        endcase
      end
      op = cur;
      if (m_upc != 1 && m_upc != 2 && ($urandom % 3) == 0) op = 6'($urandom);
      if (m_upc == 2 && ($urandom % 16) == 0) op = 6'($urandom);
      step(op, (m_upc == 0 || m_upc >= 3) && op != cur ? "R11" : "");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule